// File: doc/BRIEF.md
# Parallel-to-Serial Shift Register

This block turns a byte presented on a parallel bus into a bit stream. It keeps a row of stages. On each rising clock edge, with the active-low enable asserted, the block does one of two things. It captures the whole bus into the row, or it moves every stage one place toward the output end and takes a new bit from the serial input. With the enable deasserted the row keeps its value. Only the far-end stage leaves the block, as the serial output.

An active-low clear empties the row at once, without waiting for a clock edge, and it overrules every other input. Registers can be cascaded: feed the serial output of one into the serial input of the next. Load both on the same edge, and the pair behaves as a single register of twice the width.

The mode comes from a small decode with three named states: OP_LOAD, OP_SHIFT and OP_HOLD. The decode is combinational and is re-evaluated every cycle from the enable and the load select:

- OP_HOLD is chosen when the enable is high.
- OP_LOAD is chosen when the enable is low and the load select is low.
- OP_SHIFT is chosen when the enable is low and the load select is high.

Any state can follow any other state on the next cycle.

Top module: `pisr_shift8`

## Requirements
- R1: A rising edge with `ce_n`=0 and `ld_n`=0 (OP_LOAD) copies `par_in[k]` into stage k for every k. `ser_out` then shows `par_in[7]`.
- R2: A rising edge with `ce_n`=0 and `ld_n`=1 (OP_SHIFT) moves `ser_in` into stage 0 and moves old stage k-1 into stage k. After a load, the output therefore presents bits 7, 6, … 0 on successive shift edges.
- R3: During OP_LOAD the value on `ser_in` has no effect on any stage.
- R4: A rising edge with `ce_n`=1 (OP_HOLD) leaves every stage unchanged, whatever `ld_n`, `ser_in` and `par_in` carry.
- R5: `rst_n`=0 forces every stage to 0 immediately, between clock edges, and `ser_out` follows at once.
- R6: While `rst_n`=0, clock edges in any mode leave every stage at 0.
- R7: Bringing `ld_n` low between edges does not change any stage before the next rising edge.
- R8: Two instances chained `ser_out`→`ser_in` and loaded on the same edge act as one 16-bit register. The upstream byte follows the downstream byte out of the downstream output, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| ce_n | input | 1 | Clock enable, active low |
| ld_n | input | 1 | Parallel load select, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH (8) | Parallel data, bit k to stage k |
| ser_out | output | 1 | Value of the last stage |

## Verification
The bench drives a two-register chain and targets several corner cases:

- **Bit order on a 16-bit unload.** A reversed stage order, or a load that mapped bits backwards, would emit the word in the wrong sequence.
- **Hold edges with a load request and changing data.** The load select is pulled low and the data changes while the enable is high. A design that gave the load select priority over the enable would corrupt the partly shifted word. The corruption shows when the rest of the word is shifted out.
- **Load select falling mid-cycle.** This exposes a load that acts on the level instead of the edge.
- **Clear asserted mid-cycle while the register holds ones.** This catches a clear that waits for a clock edge.
- **Loads attempted during clear.** These catch a clear that does not dominate.

// File: rtl/pisr_pkg.sv
package pisr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } pisr_op_e;
endpackage

// File: rtl/pisr_mode_decode.sv
module pisr_mode_decode
    import pisr_pkg::*;
(
    input  logic     ce_n,
    input  logic     ld_n,
    output pisr_op_e op
);
    // Enable dominates; load select picks between load and shift.
    always_comb begin
        unique case ({ce_n, ld_n})
            2'b00:   op = OP_LOAD;
            2'b01:   op = OP_SHIFT;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/pisr_stage_array.sv
module pisr_stage_array
    import pisr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pisr_op_e         op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stages
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_stage
            logic bit_q;
            logic shift_src;

            if (i == 0) begin : g_head
                assign shift_src = ser_in;
            end else begin : g_body
                assign shift_src = stages[i-1];
            end

            // State register: asynchronous clear, synchronous enable.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else begin
                    unique case (op)
                        OP_LOAD:  bit_q <= par_in[i];
                        OP_SHIFT: bit_q <= shift_src;
                        OP_HOLD:  bit_q <= bit_q;
                        default:  bit_q <= bit_q;
                    endcase
                end
            end

            assign stages[i] = bit_q;
        end
    endgenerate
endmodule

// File: rtl/pisr_shift8.sv
module pisr_shift8
    import pisr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             ld_n,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);
    localparam int LAST = WIDTH - 1;

    pisr_op_e         op;
    logic [WIDTH-1:0] stages;

    pisr_mode_decode u_decode (
        .ce_n (ce_n),
        .ld_n (ld_n),
        .op   (op)
    );

    pisr_stage_array #(.WIDTH(WIDTH)) u_stages (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .ser_in (ser_in),
        .par_in (par_in),
        .stages (stages)
    );

    // Output process: only the last stage is visible.
    always_comb begin
        ser_out = stages[LAST];
    end
endmodule

// File: rtl/pisr_shift8_chk.sv
module pisr_shift8_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             ld_n,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] stages
);
    // R1 and R3: a load edge copies the bus and ignores the serial input
    a_r1_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !ld_n) |=> (stages == $past(par_in)));

    // R2: a shift edge moves every stage one place up
    a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ld_n) |=> (stages == {$past(stages[WIDTH-2:0]), $past(ser_in)}));

    // R4: a disabled edge leaves every stage unchanged
    a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(stages));

    // R5 and R6: the clear has already emptied the row by any edge it covers
    a_r6_clear_dominates: assert property (@(posedge clk)
        !rst_n |-> (stages == '0));
endmodule

bind pisr_shift8 pisr_shift8_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .ld_n   (ld_n),
    .ser_in (ser_in),
    .par_in (par_in),
    .stages (stages)
);

// File: tb/pisr_shift8_tb.sv
module pisr_shift8_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        ld_n = 1'b1;
    logic        head_sin = 1'b0;
    logic [15:0] word = 16'h0000;
    logic        link;
    logic        tail_out;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic [15:0] mdl = 16'h0000;

    typedef struct {
        logic  exp_tail;
        logic  exp_head;
        string req;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    pisr_shift8 u_head (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ld_n(ld_n),
        .ser_in(head_sin), .par_in(word[7:0]), .ser_out(link)
    );

    pisr_shift8 u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ld_n(ld_n),
        .ser_in(link), .par_in(word[15:8]), .ser_out(tail_out)
    );

    task automatic check(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual tail/head=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: apply one cycle and push the expected chain outputs after it.
    task automatic step(input logic ce, input logic ld, input logic sin,
                        input logic [15:0] w, input string req);
        item_t it;
        @(negedge clk);
        ce_n = ce; ld_n = ld; head_sin = sin; word = w;
        @(posedge clk);
        if (!ce) begin
            if (!ld) mdl = w;
            else     mdl = {mdl[14:0], sin};
        end
        #1;
        it.exp_tail = mdl[15];
        it.exp_head = mdl[7];
        it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: compare the oldest expectation on the following falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check({tail_out, link} == {it.exp_tail, it.exp_head}, it.req,
                  {tail_out, link}, {it.exp_tail, it.exp_head});
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state (R5)
        @(negedge clk); @(negedge clk);
        check({tail_out, link} == 2'b00, "R5", {tail_out, link}, 2'b00);
        rst_n = 1'b1;

        // R1 load, then R2/R8 unload of 16 bits MSB first
        step(1'b0, 1'b0, 1'b0, 16'hB4D3, "R1");
        for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 1'b0, 16'h0000, "R8");
        for (int i = 0; i < 4; i++)  step(1'b0, 1'b1, 1'b1, 16'h0000, "R2");

        // R3: serial input high during load is ignored
        step(1'b0, 1'b0, 1'b1, 16'h0001, "R3");
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 1'b0, 16'h0000, "R3");

        // R4: hold edges with load requested and changing data
        step(1'b0, 1'b0, 1'b0, 16'hA5C3, "R1");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 16'h0000, "R2");
        step(1'b1, 1'b0, 1'b1, 16'hFFFF, "R4");
        step(1'b1, 1'b0, 1'b0, 16'h0000, "R4");
        step(1'b1, 1'b1, 1'b1, 16'h5A5A, "R4");
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 1'b0, 16'h0000, "R4");

        // R7: load select falls mid-cycle; nothing changes before the edge
        step(1'b0, 1'b0, 1'b0, 16'h0000, "R1");
        @(negedge clk);
        #3;
        word = 16'hFFFF; ld_n = 1'b0; ce_n = 1'b0;
        #4;
        check({tail_out, link} == 2'b00, "R7", {tail_out, link}, 2'b00);
        ce_n = 1'b1; ld_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 16'hFFFF, "R1");

        // R5: clear asserted between edges acts at once
        @(negedge clk);
        #3;
        rst_n = 1'b0;
        #2;
        check({tail_out, link} == 2'b00, "R5", {tail_out, link}, 2'b00);
        mdl = 16'h0000;

        // R6: loads while clear is held do nothing
        ce_n = 1'b0; ld_n = 1'b0; word = 16'hFFFF;
        @(posedge clk); @(posedge clk);
        #2;
        check({tail_out, link} == 2'b00, "R6", {tail_out, link}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1; ce_n = 1'b1;

        // Normal operation after release: ones shifted through the chain (R2, R8)
        for (int i = 0; i < 17; i++) step(1'b0, 1'b1, 1'b1, 16'h0000, "R8");
        step(1'b0, 1'b0, 1'b0, 16'h8001, "R1");
        for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 1'b0, 16'h0000, "R2");

        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule